// File: doc/BRIEF.md
# Repeating Bus Master Sequencer

This block turns one decoded command into a run of single-word bus cycles. A command gives a direction (read or write), a start address, one write data word and a repeat count. The block asks an arbiter for the bus, waits for the grant, and then runs one access per word at consecutive addresses. The data buses are split: one drives out and one comes in. Every access moves the full data-bus width.

Each access ends on the first of three events: the slave acknowledges, the slave signals an error, or a programmable watchdog expires. Every finished access gives a one-cycle report to a downstream formatter. The report carries a status code, the address, the read word and a flag that marks the final report of the command. An error or a timeout abandons the rest of the command and hands the bus back.

Between accesses the block leaves the bus idle for at least one cycle but keeps its request raised. It starts the next word only while the grant is present. A system with no other master can tie the grant high.

Top module: `bus_repeat_seq`

## Requirements
- R1: `cmd_ready_o` is high exactly when the block is idle, and `bus_req_o` is low then. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high, and `bus_req_o` is high from the next cycle. `cmd_valid_i` has no effect while `cmd_ready_o` is low.
- R2: `cyc_o` is never high while `bus_req_o` is low. `cyc_o` rises only in the cycle after an edge where `bus_gnt_i` was sampled high with the request raised. While the grant stays low, no access starts.
- R3: `stb_o` always equals `cyc_o`. `we_o` is high during the accesses of a write command and low at all other times.
- R4: Access k of a command (k from 0) uses address start+k modulo 2^AW. A command performs `cmd_count_i` accesses, and a count of 0 performs exactly one.
- R5: An access ends at the first edge where `ack_i` or `err_i` is sampled high while `cyc_o` is high, and `cyc_o` is low in the next cycle. Between two accesses of one command, `cyc_o` is low for at least one cycle and `bus_req_o` stays high.
- R6: With `wd_limit_i` = L > 0, an access that gets no acknowledge or error ends after L cycles of `cyc_o` with status 2 (timeout). With L = 0 the watchdog is disabled.
- R7: `err_i` gives status 1 (error). It wins over `ack_i` when both are sampled high in the same cycle.
- R8: After an error or a timeout, no further access of that command is started. That report has `rpt_last_o` high, and `bus_req_o` is low in the same cycle.
- R9: Each finished access produces exactly one `rpt_valid_o` pulse, in the cycle after the edge that ended it. The status codes are 0 ok, 1 error and 2 timeout. The report also gives the access address and `rpt_last_o`, which is high only on the final report of a command.
- R10: `bus_req_o` falls, and `cmd_ready_o` rises, in the cycle that carries the final report.
- R11: A write command drives its full-width data word unchanged on `dat_o` in every access. An ok read reports the full-width `dat_i` word sampled on the acknowledge edge. Every other report carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block idle, command accepted |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | AW | Start address |
| cmd_data_i | input | DW | Write data word |
| cmd_count_i | input | CW | Number of accesses (0 means 1) |
| wd_limit_i | input | TW | Watchdog limit in cycles (0 disables) |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_gnt_i | input | 1 | Bus grant from arbiter |
| cyc_o | output | 1 | Bus cycle active |
| stb_o | output | 1 | Strobe, equal to cyc_o |
| we_o | output | 1 | Write enable |
| adr_o | output | AW | Word address |
| dat_o | output | DW | Write data out |
| dat_i | input | DW | Read data in |
| ack_i | input | 1 | Slave acknowledge |
| err_i | input | 1 | Slave error |
| rpt_valid_o | output | 1 | One-cycle report strobe |
| rpt_status_o | output | 2 | 0 ok, 1 error, 2 timeout |
| rpt_addr_o | output | AW | Address of reported access |
| rpt_data_o | output | DW | Read data, zero otherwise |
| rpt_last_o | output | 1 | Final report of the command |

## Verification
The bench targets the boundary of the count field. A count of zero must give exactly one access, and a run that crosses the top of the address space must wrap to zero. A design off by one here gives a missing access, an extra access or a wrong address. The bench holds the grant low after a command and raises the valid strobe while the block is busy. Without these, a block that ignores the arbiter drives the bus early, and a block that accepts commands out of turn gives extra reports. It provokes a slave error in the middle of a run, an error together with an acknowledge, a slave that never answers with the watchdog on and with it off, and a slow slave just under the limit. These expose a block that keeps going after a failure, reports the wrong status, or ends a cycle one clock early or late.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    RS_OK  = 2'd0,
    RS_ERR = 2'd1,
    RS_TMO = 2'd2
  } rpt_status_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_BUS  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/brs_watchdog.sv
module brs_watchdog #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  localparam logic [TW:0] CNT_MAX = {1'b0, {TW{1'b1}}};

  logic [TW:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // expire at the end of the limit-th cycle of the access
  assign expire_o = run_i && (limit_i != '0) && ((cnt_q + 1'b1) >= {1'b0, limit_i});

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/brs_addr_ctr.sv
module brs_addr_ctr #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic [CW-1:0] count_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= CW'(1);
    end else if (load_i) begin
      addr_q <= start_i;
      left_q <= (count_i == '0) ? CW'(1) : count_i;
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (left_q == CW'(1));

  a_r4_no_step_past_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);
  a_r4_addr_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/brs_report.sv
module brs_report #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [1:0]    status_i,
  input  logic          write_i,
  input  logic          last_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic          valid_o,
  output logic [1:0]    status_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  import brs_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      status_o <= RS_OK;
      addr_o   <= '0;
      data_o   <= '0;
      last_o   <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        status_o <= status_i;
        addr_o   <= addr_i;
        data_o   <= (status_i == RS_OK && !write_i) ? rdata_i : '0;
        last_o   <= last_i;
      end
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/bus_repeat_seq.sv
module bus_repeat_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic [CW-1:0] cmd_count_i,
  input  logic [TW-1:0] wd_limit_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          cyc_o,
  output logic          stb_o,
  output logic          we_o,
  output logic [AW-1:0] adr_o,
  output logic [DW-1:0] dat_o,
  input  logic [DW-1:0] dat_i,
  input  logic          ack_i,
  input  logic          err_i,
  output logic          rpt_valid_o,
  output logic [1:0]    rpt_status_o,
  output logic [AW-1:0] rpt_addr_o,
  output logic [DW-1:0] rpt_data_o,
  output logic          rpt_last_o
);
  import brs_pkg::*;

  seq_state_e  state_q, state_d;
  logic        we_q;
  logic [DW-1:0] wdata_q;
  logic        accept, in_bus, expire, done, more, last;
  rpt_status_e status;
  logic [AW-1:0] cur_addr;

  assign in_bus = (state_q == SQ_BUS);
  assign accept = (state_q == SQ_IDLE) && cmd_valid_i;
  assign done   = in_bus && (ack_i || err_i || expire);

  always_comb begin
    if (err_i)      status = RS_ERR;
    else if (ack_i) status = RS_OK;
    else            status = RS_TMO;
  end

  assign more = done && (status == RS_OK) && !last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (cmd_valid_i) state_d = SQ_REQ;
      SQ_REQ:  if (bus_gnt_i)   state_d = SQ_BUS;
      SQ_BUS:  if (done)        state_d = more ? SQ_REQ : SQ_IDLE;
      default:                  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q    <= cmd_write_i;
        wdata_q <= cmd_data_i;
      end
    end
  end

  brs_addr_ctr #(.AW(AW), .CW(CW)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .start_i (cmd_addr_i),
    .count_i (cmd_count_i),
    .step_i  (more),
    .addr_o  (cur_addr),
    .last_o  (last)
  );

  brs_watchdog #(.TW(TW)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_bus),
    .limit_i  (wd_limit_i),
    .expire_o (expire)
  );

  brs_report #(.AW(AW), .DW(DW)) u_rpt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .status_i (status),
    .write_i  (we_q),
    .last_i   (!more),
    .addr_i   (cur_addr),
    .rdata_i  (dat_i),
    .valid_o  (rpt_valid_o),
    .status_o (rpt_status_o),
    .addr_o   (rpt_addr_o),
    .data_o   (rpt_data_o),
    .last_o   (rpt_last_o)
  );

  assign cmd_ready_o = (state_q == SQ_IDLE);
  assign bus_req_o   = (state_q != SQ_IDLE);
  assign cyc_o       = in_bus;
  assign stb_o       = in_bus;
  assign we_o        = in_bus && we_q;
  assign adr_o       = cur_addr;
  assign dat_o       = we_q ? wdata_q : '0;

  a_r1_ready_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !bus_req_o);
  a_r1_req_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> bus_req_o);
  a_r2_cyc_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o |-> bus_req_o);
  a_r2_cyc_after_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cyc_o) |-> $past(bus_gnt_i));
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && (ack_i || err_i)) |=> !cyc_o);
  a_r9_report_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && (ack_i || err_i)) |=> rpt_valid_o);
  a_r7_err_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && err_i) |=> (rpt_status_o == RS_ERR));
  a_r8_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && rpt_status_o != RS_OK) |-> (rpt_last_o && !bus_req_o));
  a_r6_tmo_no_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && rpt_status_o == RS_TMO) |-> $past(cyc_o && !ack_i && !err_i));
endmodule

// File: tb/bus_repeat_seq_tb_top.sv
`timescale 1ns/1ps
module bus_repeat_seq_tb_top;
  localparam int AW = 8, DW = 16, CW = 4, TW = 6;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_write = 0, gnt = 1;
  logic [AW-1:0] cmd_addr = 0;
  logic [DW-1:0] cmd_data = 0;
  logic [CW-1:0] cmd_count = 0;
  logic [TW-1:0] wd_limit = 0;
  logic cmd_ready, bus_req, cyc, stb, we, ack = 0, err = 0;
  logic [AW-1:0] adr;
  logic [DW-1:0] dat_o, dat_i = 0;
  logic rv, rl;
  logic [1:0] rs;
  logic [AW-1:0] ra;
  logic [DW-1:0] rd;

  bus_repeat_seq #(.AW(AW), .DW(DW), .CW(CW), .TW(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_write_i(cmd_write), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .cmd_count_i(cmd_count), .wd_limit_i(wd_limit), .bus_req_o(bus_req),
    .bus_gnt_i(gnt), .cyc_o(cyc), .stb_o(stb), .we_o(we), .adr_o(adr),
    .dat_o(dat_o), .dat_i(dat_i), .ack_i(ack), .err_i(err),
    .rpt_valid_o(rv), .rpt_status_o(rs), .rpt_addr_o(ra), .rpt_data_o(rd),
    .rpt_last_o(rl));

  int checks = 0, errors = 0, cycles = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ---- behavioural reference model ----
  int m_st = 0;            // 0 idle, 1 requesting, 2 on bus
  int m_addr, m_left, m_wd;
  bit m_we;
  logic [DW-1:0] m_data;
  bit m_rv, m_rl;
  int m_rs, m_ra;
  logic [DW-1:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rv = 0; m_wd = 0;
    end else begin
      m_rv = 0;
      if (m_st == 0) begin
        if (cmd_valid) begin
          m_addr = cmd_addr; m_left = (cmd_count == 0) ? 1 : cmd_count;
          m_we = cmd_write; m_data = cmd_data; m_st = 1;
        end
      end else if (m_st == 1) begin
        if (gnt) begin m_st = 2; m_wd = 0; end
      end else begin
        int st; bit fin;
        fin = 1;
        if (err) st = 1;
        else if (ack) st = 0;
        else if (wd_limit != 0 && m_wd + 1 >= wd_limit) st = 2;
        else begin fin = 0; st = 0; end
        if (fin) begin
          bit nxt;
          nxt = (st == 0) && (m_left > 1);
          m_rv = 1; m_rs = st; m_ra = m_addr; m_rl = !nxt;
          m_rd = (st == 0 && !m_we) ? dat_i : '0;
          if (nxt) begin m_addr = (m_addr + 1) % (1 << AW); m_left--; m_st = 1; end
          else m_st = 0;
        end else m_wd++;
      end
    end
  end

  // ---- slave and per-cycle comparison ----
  logic [DW-1:0] mem [16];
  int s_mode = 0;   // 0 ack, 1 err at s_err_adr, 2 never answer, 3 ack+err
  int s_lat = 0, s_wait = 0, s_err_adr = 0;
  int q_adr[$], q_st[$], q_last[$];
  logic [DW-1:0] q_dat[$];
  int run_len = 0, last_run = 0;

  initial for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + 16'(i);

  always @(negedge clk) begin
    if (rst_n) begin
      bit bad;
      bad = 0;
      if (cmd_ready !== (m_st == 0)) begin bad = 1; $display("FAIL R1 cmd_ready actual=%0h expected=%0h", cmd_ready, m_st == 0); end
      if (bus_req !== (m_st != 0)) begin bad = 1; $display("FAIL R10 bus_req actual=%0h expected=%0h", bus_req, m_st != 0); end
      if (cyc !== (m_st == 2)) begin bad = 1; $display("FAIL R2 cyc actual=%0h expected=%0h", cyc, m_st == 2); end
      if (stb !== cyc) begin bad = 1; $display("FAIL R3 stb actual=%0h expected=%0h", stb, cyc); end
      if (we !== (m_st == 2 && m_we)) begin bad = 1; $display("FAIL R3 we actual=%0h expected=%0h", we, m_st == 2 && m_we); end
      if (m_st == 2 && adr !== AW'(m_addr)) begin bad = 1; $display("FAIL R4 adr actual=%0h expected=%0h", adr, m_addr); end
      if (m_st == 2 && m_we && dat_o !== m_data) begin bad = 1; $display("FAIL R11 dat_o actual=%0h expected=%0h", dat_o, m_data); end
      if (rv !== m_rv) begin bad = 1; $display("FAIL R9 rpt_valid actual=%0h expected=%0h", rv, m_rv); end
      else if (m_rv && (rs !== 2'(m_rs) || ra !== AW'(m_ra) || rd !== m_rd || rl !== m_rl)) begin
        bad = 1;
        $display("FAIL R9 report actual=%0h/%0h/%0h/%0h expected=%0h/%0h/%0h/%0h",
                 rs, ra, rd, rl, m_rs, m_ra, m_rd, m_rl);
      end
      checks++;
      if (bad) errors++;
      if (rv) begin q_adr.push_back(ra); q_st.push_back(rs); q_last.push_back(rl); q_dat.push_back(rd); end
      if (cyc) run_len++; else begin if (run_len != 0) last_run = run_len; run_len = 0; end
    end
    // slave response for the coming edge
    ack = 0; err = 0;
    if (cyc && stb) begin
      if (s_mode != 2 && s_wait == s_lat) begin
        if (s_mode == 3) begin ack = 1; err = 1; end
        else if (s_mode == 1 && int'(adr) == s_err_adr) err = 1;
        else ack = 1;
        if (!we) dat_i = mem[adr[3:0]];
        if (we && ack && !err) mem[adr[3:0]] = dat_o;
      end
      s_wait++;
    end else s_wait = 0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  task automatic clear_q();
    q_adr.delete(); q_st.delete(); q_last.delete(); q_dat.delete();
  endtask

  task automatic issue(input bit w, input int a, input logic [DW-1:0] d, input int n);
    while (!cmd_ready) @(negedge clk);
    #1;
    cmd_valid = 1; cmd_write = w; cmd_addr = AW'(a); cmd_data = d; cmd_count = CW'(n);
    @(negedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #2; end while (bus_req);
    repeat (2) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #2;
    // R1 reset state
    check(cmd_ready === 1 && bus_req === 0 && cyc === 0 && rv === 0, "R1 reset state", {cmd_ready, bus_req, cyc, rv}, 4'b1000);

    // R4/R11 write burst of four words
    clear_q();
    issue(1, 2, 16'hBEEF, 4); wait_idle();
    check(q_adr.size() == 4, "R4 write count", q_adr.size(), 4);
    check(q_adr.size() == 4 && q_adr[3] == 5 && q_last[3] == 1 && q_last[0] == 0, "R9 last flag/address", q_adr.size() ? q_adr[q_adr.size()-1] : 0, 5);
    check(mem[2] == 16'hBEEF && mem[5] == 16'hBEEF && mem[6] == 16'hA006, "R11 full word written", mem[5], 16'hBEEF);

    // R11 read back, gaps between accesses
    clear_q();
    mem[3] = 16'h1234;
    issue(0, 2, 16'h0, 3); wait_idle();
    check(q_dat.size() == 3 && q_dat[0] == 16'hBEEF && q_dat[1] == 16'h1234, "R11 read data", q_dat.size() > 1 ? q_dat[1] : 0, 16'h1234);
    check(last_run == 1, "R5 one-cycle access with immediate ack", last_run, 1);

    // R4 count zero gives one access
    clear_q();
    issue(0, 7, 16'h0, 0); wait_idle();
    check(q_adr.size() == 1 && q_adr[0] == 7 && q_last[0] == 1, "R4 zero count", q_adr.size(), 1);

    // R4 address wrap
    clear_q();
    issue(0, 8'hFE, 16'h0, 3); wait_idle();
    check(q_adr.size() == 3 && q_adr[1] == 8'hFF && q_adr[2] == 0, "R4 wrap", q_adr.size() == 3 ? q_adr[2] : -1, 0);

    // R2 grant held low, R1 valid while busy ignored
    clear_q();
    gnt = 0;
    issue(1, 9, 16'h5555, 2);
    cmd_valid = 1; cmd_addr = 8'h40; cmd_count = 1;
    repeat (5) begin
      @(negedge clk); #2;
      check(cyc === 0 && bus_req === 1, "R2 no cycle without grant", cyc, 0);
    end
    cmd_valid = 0;
    gnt = 1; wait_idle();
    check(q_adr.size() == 2 && q_adr[0] == 9 && q_adr[1] == 10, "R1 busy command ignored", q_adr.size(), 2);
    check(cmd_ready === 1 && bus_req === 0, "R10 idle after run", bus_req, 0);

    // R7/R8 error mid run
    clear_q();
    s_mode = 1; s_err_adr = 5;
    issue(0, 3, 16'h0, 6); wait_idle();
    check(q_st.size() == 3 && q_st[2] == 1 && q_last[2] == 1 && q_st[1] == 0, "R8 abort on error", q_st.size(), 3);
    check(q_dat.size() == 3 && q_dat[2] == 0, "R11 zero data on error", q_dat.size() == 3 ? q_dat[2] : 1, 0);

    // R7 ack and err together
    clear_q();
    s_mode = 3;
    issue(0, 1, 16'h0, 2); wait_idle();
    check(q_st.size() == 1 && q_st[0] == 1, "R7 err over ack", q_st.size() ? q_st[0] : -1, 1);

    // R6 timeout after exactly the limit
    clear_q();
    s_mode = 2; wd_limit = 5;
    issue(1, 4, 16'h7777, 3); wait_idle();
    check(q_st.size() == 1 && q_st[0] == 2 && q_last[0] == 1, "R6 timeout status", q_st.size() ? q_st[0] : -1, 2);
    check(last_run == 5, "R6 timeout length", last_run, 5);

    // R6 slow slave under the limit
    clear_q();
    s_mode = 0; s_lat = 3;
    issue(0, 0, 16'h0, 2); wait_idle();
    check(q_st.size() == 2 && q_st[0] == 0 && q_st[1] == 0, "R6 slow ack within limit", q_st.size(), 2);
    check(last_run == 4, "R5 access length with latency", last_run, 4);

    // R6 watchdog disabled
    clear_q();
    wd_limit = 0; s_lat = 20;
    issue(0, 6, 16'h0, 1); wait_idle();
    check(q_st.size() == 1 && q_st[0] == 0 && last_run == 21, "R6 limit zero disables", last_run, 21);

    finish_run();
  end
endmodule